// File: doc/BRIEF.md
# Row-Recursive Horizontal Smoothing Filter

This block is a first-order recursive low-pass filter for a raster image. The image arrives one 8-bit pixel at a time on a valid/ready stream. Each pixel carries a start-of-row flag and a start-of-frame flag. Within a row, each result mixes the previous result with the current pixel. The weighting comes from an 8-bit coefficient `a` that stands for the fraction a/256. The current pixel gets weight (256 − a). The recursion runs from left to right and starts again at the first pixel of every row.

The filter state is the previous 8-bit result, so the feedback loop closes inside one register stage. The block takes one pixel per clock and sends each result out one cycle after it accepts the pixel. The coefficient is sampled on the start-of-frame pixel and then held for the whole frame, so software may change the coefficient pin at any time without disturbing a frame in progress. Backpressure from the consumer holds the result and closes the input until the result is taken.

Top module: `hrec_smoother`

## Requirements
- R1: While reset is asserted and after it is released, with no pixel yet accepted, `out_valid` is 0 and `in_ready` is 1.
- R2: For a pixel that does not start a row, the result is floor((a·p + (256−a)·x + 128) / 256), capped at 255. Here x is the pixel, p is the previous 8-bit result of the same row, and a is the frame coefficient (unsigned, 0..255).
- R3: A pixel with `in_sol`=1 or `in_sof`=1 starts a row: its result equals the pixel itself, and the following pixels recurse from that value.
- R4: The frame coefficient is taken from `coef_i` on the pixel with `in_sof`=1, and it applies to that pixel. Values on `coef_i` at any other pixel have no effect. Before the first start-of-frame pixel after reset, the coefficient is 0.
- R5: A pixel accepted at a clock edge (`in_valid`=1 and `in_ready`=1) has its result on `out_valid`/`out_pix` right after that edge. The block can accept one pixel per cycle, and `out_valid` never rises without an acceptance.
- R6: `in_ready` is 1 exactly when no result is held or `out_ready` is 1. While `out_valid`=1 and `out_ready`=0, the output pixel and flags stay unchanged.
- R7: `out_sol` and `out_sof` carry the flags of the pixel whose result is presented.
- R8: With a coefficient of 0, every result equals its input pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_i | input | 8 | Smoothing coefficient a (fraction a/256), sampled on start-of-frame pixel |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_pix | input | 8 | Input pixel |
| in_sol | input | 1 | Input pixel is first of its row |
| in_sof | input | 1 | Input pixel is first of its frame |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_pix | output | 8 | Filtered pixel |
| out_sol | output | 1 | Result belongs to a row's first pixel |
| out_sof | output | 1 | Result belongs to a frame's first pixel |

## Verification
Each accepted pixel's result is due right after the accepting edge, and it stays there until the consumer's handshake edge. `in_ready` is due in the same cycle that `out_ready` changes. The bench drives inputs just after a falling edge and keeps a behavioural model with at most one pending result. It updates the model with the handshakes that will happen at the next rising edge, and then compares `out_valid`, `out_pix`, the flags and `in_ready` at the following falling edge. It does this every cycle. Test phases cover a zero coefficient, steady streaming, random gaps and backpressure, a coefficient pin that changes inside a frame, and extreme pixel patterns.

// File: rtl/hrs_pkg.sv
package hrs_pkg;

  typedef struct packed {
    logic sol;
    logic sof;
  } mark_t;

  typedef enum logic {
    RND_TRUNC   = 1'b0,
    RND_NEAREST = 1'b1
  } rnd_mode_e;

endpackage

// File: rtl/hrs_blend.sv
module hrs_blend
  import hrs_pkg::*;
#(
  parameter int        PIX_W  = 8,
  parameter int        COEF_W = 8,
  parameter rnd_mode_e RND    = RND_NEAREST
) (
  input  logic [COEF_W-1:0] a_i,
  input  logic [PIX_W-1:0]  prev_i,
  input  logic [PIX_W-1:0]  cur_i,
  output logic [PIX_W-1:0]  y_o
);
  localparam int ACC_W = PIX_W + COEF_W + 2;
  localparam logic [COEF_W:0]  ONE_V  = {1'b1, {COEF_W{1'b0}}};
  localparam logic [ACC_W-1:0] HALF_V = ACC_W'(ONE_V >> 1);

  logic [COEF_W:0]  w_cur;
  logic [ACC_W-1:0] acc_raw;
  logic [ACC_W-1:0] acc_rnd;
  logic [ACC_W-1:0] acc_sh;

  always_comb begin
    w_cur   = ONE_V - {1'b0, a_i};
    acc_raw = ACC_W'(a_i) * ACC_W'(prev_i) + ACC_W'(w_cur) * ACC_W'(cur_i);
  end

  generate
    if (RND == RND_NEAREST) begin : g_nearest
      always_comb acc_rnd = acc_raw + HALF_V;
    end else begin : g_trunc
      always_comb acc_rnd = acc_raw;
    end
  endgenerate

  always_comb begin
    acc_sh = acc_rnd >> COEF_W;
    if (|acc_sh[ACC_W-1:PIX_W]) y_o = '1;
    else                        y_o = acc_sh[PIX_W-1:0];
  end
endmodule

// File: rtl/hrs_row_ctx.sv
module hrs_row_ctx #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              sol_i,
  input  logic              sof_i,
  input  logic [COEF_W-1:0] coef_i,
  input  logic [PIX_W-1:0]  cur_i,
  input  logic [PIX_W-1:0]  y_new_i,
  output logic [COEF_W-1:0] a_eff_o,
  output logic [PIX_W-1:0]  prev_eff_o
);
  logic [COEF_W-1:0] coef_q, coef_d;
  logic [PIX_W-1:0]  yprev_q, yprev_d;
  logic              restart;

  always_comb begin
    restart    = sol_i | sof_i;
    a_eff_o    = sof_i   ? coef_i : coef_q;
    prev_eff_o = restart ? cur_i  : yprev_q;
  end

  always_comb begin
    coef_d  = (take_i && sof_i) ? coef_i : coef_q;
    yprev_d = take_i ? y_new_i : yprev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_q  <= '0;
      yprev_q <= '0;
    end else begin
      coef_q  <= coef_d;
      yprev_q <= yprev_d;
    end
  end
endmodule

// File: rtl/hrs_out_stage.sv
module hrs_out_stage
  import hrs_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  output logic             take_o,
  input  logic [PIX_W-1:0] pix_d_i,
  input  mark_t            mark_d_i,
  input  logic             out_ready_i,
  output logic             out_valid_o,
  output logic [PIX_W-1:0] out_pix_o,
  output mark_t            out_mark_o
);
  logic             vld_q, vld_d;
  logic [PIX_W-1:0] pix_q;
  mark_t            mark_q;

  always_comb begin
    in_ready_o = !vld_q || out_ready_i;
    take_o     = in_valid_i && in_ready_o;
    if (take_o)           vld_d = 1'b1;
    else if (out_ready_i) vld_d = 1'b0;
    else                  vld_d = vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q  <= '0;
      mark_q <= '0;
    end else if (take_o) begin
      pix_q  <= pix_d_i;
      mark_q <= mark_d_i;
    end
  end

  assign out_valid_o = vld_q;
  assign out_pix_o   = pix_q;
  assign out_mark_o  = mark_q;
endmodule

// File: rtl/hrec_smoother.sv
module hrec_smoother
  import hrs_pkg::*;
#(
  parameter int        PIX_W  = 8,
  parameter int        COEF_W = 8,
  parameter rnd_mode_e RND    = RND_NEAREST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COEF_W-1:0] coef_i,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_pix,
  input  logic              in_sol,
  input  logic              in_sof,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_pix,
  output logic              out_sol,
  output logic              out_sof
);
  logic              take;
  logic [COEF_W-1:0] a_eff;
  logic [PIX_W-1:0]  prev_eff;
  logic [PIX_W-1:0]  y_new;
  mark_t             mark_in;
  mark_t             mark_out;

  always_comb begin
    mark_in.sol = in_sol;
    mark_in.sof = in_sof;
  end

  hrs_row_ctx #(.PIX_W(PIX_W), .COEF_W(COEF_W)) u_ctx (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_i     (take),
    .sol_i      (in_sol),
    .sof_i      (in_sof),
    .coef_i     (coef_i),
    .cur_i      (in_pix),
    .y_new_i    (y_new),
    .a_eff_o    (a_eff),
    .prev_eff_o (prev_eff)
  );

  hrs_blend #(.PIX_W(PIX_W), .COEF_W(COEF_W), .RND(RND)) u_blend (
    .a_i    (a_eff),
    .prev_i (prev_eff),
    .cur_i  (in_pix),
    .y_o    (y_new)
  );

  hrs_out_stage #(.PIX_W(PIX_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .take_o      (take),
    .pix_d_i     (y_new),
    .mark_d_i    (mark_in),
    .out_ready_i (out_ready),
    .out_valid_o (out_valid),
    .out_pix_o   (out_pix),
    .out_mark_o  (mark_out)
  );

  assign out_sol = mark_out.sol;
  assign out_sof = mark_out.sof;
endmodule

// File: rtl/hrec_smoother_chk.sv
module hrec_smoother_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [PIX_W-1:0] in_pix,
  input logic             in_sol,
  input logic             in_sof,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_pix,
  input logic             out_sol,
  input logic             out_sof
);
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(out_sol) && $stable(out_sof)); // R6
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R6
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R5
  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready)); // R5
  AST_ROW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_sol || in_sof) |=> out_pix == $past(in_pix)); // R3
  AST_MARKS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_sol == $past(in_sol) && out_sof == $past(in_sof)); // R7
endmodule

bind hrec_smoother hrec_smoother_chk #(.PIX_W(PIX_W)) u_chk (.*);

// File: tb/hrec_smoother_test.sv
module hrec_smoother_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] coef_i;
  logic       in_valid, in_ready, in_sol, in_sof;
  logic [7:0] in_pix;
  logic       out_valid, out_ready, out_sol, out_sof;
  logic [7:0] out_pix;

  always #(CLK_PERIOD/2) clk = ~clk;

  hrec_smoother uut (
    .clk(clk), .rst_n(rst_n), .coef_i(coef_i),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .in_sol(in_sol), .in_sof(in_sof),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
    .out_sol(out_sol), .out_sof(out_sof)
  );

  typedef struct {int pix; bit sol; bit sof;} exp_t;
  exp_t  q[$];
  int    m_yp = 0;
  int    m_fa = 0;
  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  bit    stall_mode = 1'b0;
  string phase = "R2";

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_outputs();
    check(out_valid == (q.size() != 0), "R5", "out_valid", out_valid, q.size() != 0);
    if (q.size() != 0) begin
      check(out_pix == q[0].pix, (q[0].sol || q[0].sof) ? "R3" : phase, "out_pix", out_pix, q[0].pix);
      check(out_sol == q[0].sol && out_sof == q[0].sof, "R7", "flags",
            {out_sol, out_sof}, {q[0].sol, q[0].sof});
    end
  endtask

  // Called after inputs are set for a cycle: predicts the coming edge.
  task automatic model_edge();
    bit exp_rdy;
    #1;
    exp_rdy = (q.size() == 0) || out_ready;
    check(in_ready == exp_rdy, "R6", "in_ready", in_ready, exp_rdy);
    if (q.size() != 0 && out_ready) void'(q.pop_front());
    if (in_valid && exp_rdy) begin
      int a, base, y;
      exp_t e;
      a = in_sof ? int'(coef_i) : m_fa;
      if (in_sof) m_fa = int'(coef_i);
      base = (in_sol || in_sof) ? int'(in_pix) : m_yp;
      y = (a * base + (256 - a) * int'(in_pix) + 128) / 256;
      if (y > 255) y = 255;
      m_yp = y;
      e.pix = y; e.sol = in_sol; e.sof = in_sof;
      q.push_back(e);
    end
    @(negedge clk);
    compare_outputs();
  endtask

  task automatic send_px(input int pix, input bit sol, input bit sof, input int coef);
    bit acc = 1'b0;
    while (!acc) begin
      out_ready = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
      if (stall_mode && $urandom_range(0, 3) == 0) begin
        in_valid = 1'b0;
        coef_i = 8'($urandom_range(0, 255));
        model_edge();
      end else begin
        in_valid = 1'b1; in_pix = 8'(pix); in_sol = sol; in_sof = sof; coef_i = 8'(coef);
        #1;
        acc = in_ready;
        #0;
        model_edge_noskip();
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic model_edge_noskip();
    bit exp_rdy;
    exp_rdy = (q.size() == 0) || out_ready;
    check(in_ready == exp_rdy, "R6", "in_ready", in_ready, exp_rdy);
    if (q.size() != 0 && out_ready) void'(q.pop_front());
    if (in_valid && exp_rdy) begin
      int a, base, y;
      exp_t e;
      a = in_sof ? int'(coef_i) : m_fa;
      if (in_sof) m_fa = int'(coef_i);
      base = (in_sol || in_sof) ? int'(in_pix) : m_yp;
      y = (a * base + (256 - a) * int'(in_pix) + 128) / 256;
      if (y > 255) y = 255;
      m_yp = y;
      e.pix = y; e.sol = in_sol; e.sof = in_sof;
      q.push_back(e);
    end
    @(negedge clk);
    compare_outputs();
  endtask

  // pattern: 0 random, 1 alternating extremes, 2 ramp
  task automatic send_frame(input int rows, input int cols, input int coef,
                            input int pattern, input bit vary, input bit with_sof);
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < cols; c++) begin
        int px, cf;
        bit first;
        first = with_sof && r == 0 && c == 0;
        case (pattern)
          1:       px = ((c + r) % 2 == 0) ? 255 : 0;
          2:       px = (c * 23 + r * 7) % 256;
          default: px = $urandom_range(0, 255);
        endcase
        cf = (first || !vary) ? coef : $urandom_range(0, 255);
        send_px(px, c == 0, first, cf);
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b0; out_ready = 1'b1;
      model_edge();
    end
  endtask

  initial begin
    rst_n = 1'b0; coef_i = '0; in_valid = 1'b0; in_pix = '0;
    in_sol = 1'b0; in_sof = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1", "reset idle", {out_valid, in_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1", "after release", {out_valid, in_ready}, 2'b01);
    compare_outputs();

    // Before any start-of-frame: coefficient 0, coef_i ignored (R4)
    phase = "R4";
    send_frame(2, 8, 200, 0, 1'b1, 1'b0);
    idle(2);

    // Zero coefficient: pass-through (R8)
    phase = "R8";
    send_frame(2, 6, 0, 2, 1'b0, 1'b1);
    idle(2);

    // Steady streaming (R2)
    phase = "R2";
    send_frame(3, 10, 200, 0, 1'b0, 1'b1);
    send_frame(2, 12, 255, 1, 1'b0, 1'b1);
    send_frame(2, 12, 1, 1, 1'b0, 1'b1);
    send_frame(2, 9, 128, 2, 1'b0, 1'b1);

    // Gaps and backpressure (R6)
    phase = "R6";
    stall_mode = 1'b1;
    send_frame(4, 12, 77, 0, 1'b0, 1'b1);

    // Coefficient pin moving inside frames (R4)
    phase = "R4";
    send_frame(3, 10, 100, 0, 1'b1, 1'b1);
    stall_mode = 1'b0;
    send_frame(3, 10, 255, 0, 1'b1, 1'b1);
    idle(4);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule